// File: doc/BRIEF.md
# Stuck Data Line Watchdog

This block watches the data line of a two-wire serial target port. A bus controller can stop clocking part way through a transfer while the local target still pulls the data line low, for example during an acknowledge bit or a zero data bit. When that happens, the bus controller cannot issue a new start condition, and the bus stays hung. The watchdog takes a sparse sample of the synchronized data level once every poll period. It counts consecutive low samples taken while the host side is powered. When that count reaches a limit, it resets the target controller.

A sample that sees the line high, or that is taken while the host is unpowered, clears the low count. A completed write transaction from the target controller also clears it, because the target has released the line at that point. The limit of three low samples allows two legitimate transactions to fall on poll instants between write completions. Each recovery emits a single-cycle reinitialization pulse, increments a saturating recovery counter, and restarts the poll schedule from zero. The poll period is built from a prescaler and a tick counter, and both terminal counts are parameters.

Top module: `sda_stall_guard`

## Requirements
- R1: With `P = PRE_DIV * POLL_TICKS`, the data line is sampled at the clock edges numbered P, 2P, 3P, … after reset release, where the first rising edge with `rst_n` high is edge 1.
- R2: A sample that sees `sda_i` high, or one taken while `host_on_i` is low, sets the low count to zero.
- R3: A sample that sees `sda_i` low while `host_on_i` is high adds one to the low count. The sample that brings the count to LOW_LIMIT (default 3) clears the count and raises `reinit_o` in the cycle that follows that sample edge.
- R4: `write_done_i` high at a clock edge clears the low count. If it coincides with a sample edge, it wins, and that sample is not counted.
- R5: `reinit_o` is high for exactly one cycle, and no sample is taken at the edge that ends that cycle.
- R6: `recov_cnt_o` is zero after reset. It rises by one in the same cycle that `reinit_o` goes high and changes at no other time.
- R7: `recov_cnt_o` saturates at all ones and never wraps. `reinit_o` still pulses once the counter is saturated.
- R8: A recovery restarts the poll schedule. If `reinit_o` is high after edge E, the next samples fall at edges E+1+P, E+1+2P, …, so a line held low gives pulses 3P+1 cycles apart.
- R9: While `host_on_i` stays low, `reinit_o` never rises, whatever the data line does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | Synchronized data line level |
| host_on_i | input | 1 | High while the bus host side is powered |
| write_done_i | input | 1 | One-cycle event: target finished a write transaction |
| reinit_o | output | 1 | One-cycle request to reinitialize the target controller |
| recov_cnt_o | output | REC_W | Saturating count of recoveries issued |

## Verification
The bench runs with a 20-cycle poll period and measures the exact edge of each reinit pulse.

- **Schedule.** A schedule that is off by one, or that does not restart, moves the first pulse away from cycle 60 or the second away from cycle 121.
- **Clearing.** A single high sample or unpowered sample is inserted inside a low run, and a write-done event lands mid-run. If either fails to clear the count, the pulse comes early.
- **Collision.** A write-done event placed exactly on a sample edge shows which of the two wins. A design that lets the sample win fires at cycle 60 instead of 120.
- **Saturation.** A narrow recovery counter is driven past its maximum. A counter that wraps reads back zero, and one that gates the pulse stops pulsing.

// File: rtl/sdaw_pkg.sv
package sdaw_pkg;

   // Outcome of one poll instant for the low-sample tracker
   typedef enum logic [1:0] {
      SMP_IDLE  = 2'd0,
      SMP_CLEAR = 2'd1,
      SMP_COUNT = 2'd2
   } smp_e;

   // Width needed to hold values 0..n-1, never below one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic smp_e classify(input logic poll, input logic sda,
                                     input logic host_on);
      if (!poll)
         return SMP_IDLE;
      else if (!host_on || sda)
         return SMP_CLEAR;
      else
         return SMP_COUNT;
   endfunction

endpackage

// File: rtl/sdaw_poll_timer.sv
module sdaw_poll_timer #(
   parameter int unsigned PRE_DIV    = 125000,
   parameter int unsigned POLL_TICKS = 700
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   output logic poll_o
);
   localparam int unsigned PW = sdaw_pkg::idx_w(PRE_DIV);
   localparam int unsigned TW = sdaw_pkg::idx_w(POLL_TICKS);

   logic tick;
   logic [TW-1:0] tick_q;

   generate
      if (PRE_DIV < 1) begin : g_bad_div
         $error("PRE_DIV must be at least 1");
      end
      if (POLL_TICKS < 1) begin : g_bad_ticks
         $error("POLL_TICKS must be at least 1");
      end

      if (PRE_DIV == 1) begin : g_no_pre
         assign tick = 1'b1;
      end else begin : g_pre
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_q <= '0;
            else if (restart_i || pre_q == PW'(PRE_DIV - 1))
               pre_q <= '0;
            else
               pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == PW'(PRE_DIV - 1));
      end

      if (POLL_TICKS == 1) begin : g_one_tick
         assign tick_q = '0;
      end else begin : g_ticks
         logic [TW-1:0] tq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tq <= '0;
            else if (restart_i)
               tq <= '0;
            else if (tick)
               tq <= (tq == TW'(POLL_TICKS - 1)) ? '0 : tq + 1'b1;
         end
         assign tick_q = tq;
      end
   endgenerate

   assign poll_o = tick && (tick_q == TW'(POLL_TICKS - 1));

endmodule

// File: rtl/sdaw_low_tracker.sv
module sdaw_low_tracker #(
   parameter int unsigned LOW_LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic poll_i,
   input  logic sda_i,
   input  logic host_on_i,
   input  logic write_done_i,
   output logic hit_o
);
   import sdaw_pkg::*;

   localparam int unsigned LW = idx_w(LOW_LIMIT + 1);

   generate
      if (LOW_LIMIT < 1) begin : g_bad_limit
         $error("LOW_LIMIT must be at least 1");
      end
   endgenerate

   logic [LW-1:0] low_q;
   smp_e          verdict;

   assign verdict = classify(poll_i && !write_done_i, sda_i, host_on_i);
   assign hit_o   = (verdict == SMP_COUNT) && (low_q == LW'(LOW_LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q <= '0;
      end else if (write_done_i) begin
         low_q <= '0;
      end else begin
         unique case (verdict)
            SMP_CLEAR: low_q <= '0;
            SMP_COUNT: low_q <= hit_o ? '0 : low_q + 1'b1;
            default:   low_q <= low_q;
         endcase
      end
   end

endmodule

// File: rtl/sdaw_sat_counter.sv
module sdaw_sat_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   generate
      if (W < 1) begin : g_bad_w
         $error("W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (inc_i && cnt_q != TOP)
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/sda_stall_guard.sv
module sda_stall_guard #(
   parameter int unsigned PRE_DIV    = 125000,
   parameter int unsigned POLL_TICKS = 700,
   parameter int unsigned LOW_LIMIT  = 3,
   parameter int unsigned REC_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_i,
   input  logic             host_on_i,
   input  logic             write_done_i,
   output logic             reinit_o,
   output logic [REC_W-1:0] recov_cnt_o
);
   logic poll_raw;
   logic poll_gated;
   logic hit;
   logic reinit_q;

   sdaw_poll_timer #(
      .PRE_DIV   (PRE_DIV),
      .POLL_TICKS(POLL_TICKS)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart_i(reinit_q),
      .poll_o   (poll_raw)
   );

   // no sample is taken during the reinit cycle
   assign poll_gated = poll_raw && !reinit_q;

   sdaw_low_tracker #(
      .LOW_LIMIT(LOW_LIMIT)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .poll_i      (poll_gated),
      .sda_i       (sda_i),
      .host_on_i   (host_on_i),
      .write_done_i(write_done_i),
      .hit_o       (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reinit_q <= 1'b0;
      else
         reinit_q <= hit;
   end

   sdaw_sat_counter #(
      .W(REC_W)
   ) u_recov (
      .clk  (clk),
      .rst_n(rst_n),
      .inc_i(hit),
      .cnt_o(recov_cnt_o)
   );

   assign reinit_o = reinit_q;

endmodule

// File: rtl/sda_stall_guard_chk.sv
module sda_stall_guard_chk #(
   parameter int unsigned REC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sda_i,
   input logic             host_on_i,
   input logic             write_done_i,
   input logic             reinit_o,
   input logic [REC_W-1:0] recov_cnt_o
);
   localparam logic [REC_W-1:0] TOP = {REC_W{1'b1}};

   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      reinit_o |=> !reinit_o); // R5

   AST_LOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      reinit_o |-> ($past(host_on_i) && !$past(sda_i))); // R3

   AST_WD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      reinit_o |-> !$past(write_done_i)); // R4

   AST_REC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (reinit_o && $past(recov_cnt_o) != TOP)
         |-> recov_cnt_o == $past(recov_cnt_o) + 1'b1); // R6

   AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reinit_o |-> $stable(recov_cnt_o)); // R6

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(recov_cnt_o) == TOP) |-> recov_cnt_o == TOP); // R7

endmodule

bind sda_stall_guard sda_stall_guard_chk #(.REC_W(REC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sda_i       (sda_i),
   .host_on_i   (host_on_i),
   .write_done_i(write_done_i),
   .reinit_o    (reinit_o),
   .recov_cnt_o (recov_cnt_o)
);

// File: tb/sda_stall_guard_bench.sv
`timescale 1ns/1ps
module sda_stall_guard_bench;
   localparam int PRE = 4;
   localparam int TK  = 5;
   localparam int P   = PRE * TK;
   localparam int RW  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sda = 1'b1;
   logic host_on = 1'b1;
   logic wdone = 1'b0;
   logic reinit;
   logic [RW-1:0] recov;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   sda_stall_guard #(
      .PRE_DIV(PRE), .POLL_TICKS(TK), .LOW_LIMIT(3), .REC_W(RW)
   ) u_sda_stall_guard (
      .clk(clk), .rst_n(rst_n), .sda_i(sda), .host_on_i(host_on),
      .write_done_i(wdone), .reinit_o(reinit), .recov_cnt_o(recov)
   );

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic go_to(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   // counts reinit cycles seen at negedges from now up to cycle n inclusive
   task automatic count_pulses(input int n, output int pulses);
      pulses = 0;
      while (cyc < n) begin
         @(negedge clk);
         if (reinit) pulses++;
      end
   endtask

   task automatic restart(input logic s, input logic h);
      @(negedge clk);
      rst_n = 1'b0;
      sda = s; host_on = h; wdone = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state;
      restart(1'b1, 1'b1);
      check_eq("R6 reset count", int'(recov), 0);
      check_eq("R5 reset pulse", int'(reinit), 0);
   endtask

   task automatic t_low_run;
      int n;
      restart(1'b0, 1'b1);
      count_pulses(3*P - 1, n);
      check_eq("R1 no pulse before third sample", n, 0);
      go_to(3*P);
      check_eq("R3 pulse after third low sample", int'(reinit), 1);
      check_eq("R6 count with pulse", int'(recov), 1);
      @(negedge clk);
      check_eq("R5 pulse one cycle", int'(reinit), 0);
      count_pulses(6*P, n);
      check_eq("R8 no pulse on old grid", n, 0);
      @(negedge clk);
      check_eq("R8 pulse at restarted grid", int'(reinit), 1);
      check_eq("R6 count second", int'(recov), 2);
   endtask

   task automatic t_high_clears;
      int n;
      restart(1'b0, 1'b1);
      go_to(45); sda = 1'b1;
      go_to(65); sda = 1'b0;
      count_pulses(6*P - 1, n);
      check_eq("R2 high sample clears", n, 0);
      @(negedge clk);
      check_eq("R2 pulse after fresh run", int'(reinit), 1);
   endtask

   task automatic t_host_off_clears;
      int n;
      restart(1'b0, 1'b1);
      go_to(45); host_on = 1'b0;
      go_to(65); host_on = 1'b1;
      count_pulses(6*P - 1, n);
      check_eq("R2 unpowered sample clears", n, 0);
      @(negedge clk);
      check_eq("R2 pulse after powered run", int'(reinit), 1);
   endtask

   task automatic t_host_off_gate;
      int n;
      restart(1'b0, 1'b0);
      count_pulses(12*P, n);
      check_eq("R9 no pulse while unpowered", n, 0);
      check_eq("R9 count untouched", int'(recov), 0);
   endtask

   task automatic t_write_done;
      int n;
      restart(1'b0, 1'b1);
      go_to(50); wdone = 1'b1;
      go_to(51); wdone = 1'b0;
      count_pulses(5*P - 1, n);
      check_eq("R4 write done clears mid run", n, 0);
      @(negedge clk);
      check_eq("R4 pulse after restart of count", int'(reinit), 1);
   endtask

   task automatic t_collision;
      int n;
      restart(1'b0, 1'b1);
      go_to(3*P - 1); wdone = 1'b1;
      go_to(3*P);     wdone = 1'b0;
      check_eq("R4 write done beats sample", int'(reinit), 0);
      count_pulses(6*P - 1, n);
      check_eq("R4 quiet until next run", n, 0);
      @(negedge clk);
      check_eq("R4 pulse after collision", int'(reinit), 1);
   endtask

   task automatic t_saturate;
      restart(1'b0, 1'b1);
      go_to(3*P + 6*(3*P + 1));
      check_eq("R7 count at max", int'(recov), 7);
      go_to(3*P + 7*(3*P + 1));
      check_eq("R7 pulse while saturated", int'(reinit), 1);
      check_eq("R7 no wrap", int'(recov), 7);
      go_to(700);
      check_eq("R7 still saturated", int'(recov), 7);
   endtask

   initial begin
      t_reset_state();
      t_low_run();
      t_high_clears();
      t_host_off_clears();
      t_host_off_gate();
      t_write_done();
      t_collision();
      t_saturate();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule